// File: doc/BRIEF.md
# Wake-on-LAN Magic Frame Detector

This block sits beside a receive MAC and watches the bytes of every incoming Ethernet frame for a wake-up frame. A wake-up frame carries a sync run of at least six 0xFF bytes, followed at once by sixteen back-to-back copies of the station's own 48-bit address. The station address is a block input. A frame counts only if its destination address is the station address, unless an accept-any-address control relaxes that check. The block judges the frame when the frame ends. If the end-of-frame strobe comes with a good CRC and detection is armed, it latches an interrupt status flag.

A five-bit control/status register holds the detection mode, the enable, the accept-any bit, the interrupt status flag and the interrupt enable. Detection is armed when the mode bit is set and either the enable bit or the power-good input is high. The status flag is write-one-to-clear. A stop control clears the flag, and a soft reset clears the whole register. The interrupt request is the status flag gated by its own enable and by a global interrupt enable input.

Top module: `wol_detect_top`

## Requirements
- R1: After hard reset, `reg_rdata` is 0 and `irq_o` is 0.
- R2: A write (`reg_we`) loads `reg_rdata` bit 0 (mode), bit 1 (enable), bit 2 (accept-any) and bit 4 (interrupt enable) from `reg_wdata`. Bit 3 is the status flag, and a write never sets it.
- R3: When accept-any is off, a frame qualifies only if its first six bytes equal `station_addr`, sent most significant byte first (`station_addr[47:40]` first).
- R4: Accept-any is the OR of register bit 2 and the `alt_accept` input. When it is on, any destination (unicast, multicast or broadcast) qualifies.
- R5: The bytes after the destination must hold at least six consecutive 0xFF bytes, followed directly by 16 consecutive copies of `station_addr` (most significant byte first). Fifteen copies do not match.
- R6: A byte that breaks the copy sequence restarts the search. If that byte is 0xFF, it counts as the first byte of a new sync run.
- R7: A match is judged only on the byte that carries `rx_eof` with `rx_crc_ok` high. The status flag reads 1 from the cycle after that byte. Every `rx_sof` byte clears the search state, and idle cycles (`rx_valid` low) inside a frame are ignored.
- R8: The flag is set only if, at the end-of-frame byte, the mode bit is 1 and either `pwr_good` or the enable bit is 1.
- R9: Writing 1 to bit 3 clears the status flag, and writing 0 leaves it unchanged. If a set and a clear fall on the same cycle, the set wins.
- R10: `irq_o` equals status AND interrupt enable AND `glb_irq_en`, with no extra delay.
- R11: A `stop_set` pulse clears only the status flag, and takes priority over a set. A `soft_rst` pulse clears every register bit and the search state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| stop_set | input | 1 | Pulse: stop control being set |
| pwr_good | input | 1 | Power-good indication |
| glb_irq_en | input | 1 | Global interrupt enable |
| alt_accept | input | 1 | Second accept-any-address bit |
| station_addr | input | 48 | Station address |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_crc_ok | input | 1 | CRC good, valid with rx_eof |
| rx_data | input | 8 | Receive byte |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 5 | Control register write data |
| reg_rdata | output | 5 | Control register contents |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes, stop and soft reset change `reg_rdata` one clock after the edge that samples them. The status flag follows the end-of-frame byte by one clock. `irq_o` follows the register with no delay, because it is combinational from the register and `glb_irq_en`. The bench drives every input just after a rising edge and advances its reference model at that same edge. It then compares `reg_rdata` and `irq_o` one time unit after each edge, so every result is checked in exactly the cycle it is due.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int CTRL_W    = 5;
  localparam int POS_W     = $clog2(MAC_BYTES);

  localparam int B_MODE = 0;
  localparam int B_EN   = 1;
  localparam int B_ACC  = 2;
  localparam int B_STAT = 3;
  localparam int B_IE   = 4;

  // byte idx of an address, most significant byte is idx 0
  function automatic logic [7:0] addr_byte(input logic [MAC_W-1:0] a,
                                           input logic [POS_W-1:0] idx);
    logic [MAC_W-1:0] sh;
    sh = a >> (8 * (MAC_BYTES - 1 - int'(idx)));
    return sh[7:0];
  endfunction
endpackage

// File: rtl/wol_dest_filter.sv
module wol_dest_filter
  import wol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic [7:0]       rx_data,
  input  logic [MAC_W-1:0] station_addr,
  output logic             dest_ok,
  output logic             in_payload
);
  localparam int IDX_W = $clog2(MAC_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(MAC_BYTES);

  logic [IDX_W-1:0] idx_q;
  logic             acc_q;
  logic [POS_W-1:0] pos;

  assign pos = POS_W'(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= 1'b0;
    end else if (soft_rst) begin
      idx_q <= '0;
      acc_q <= 1'b0;
    end else if (rx_valid) begin
      if (rx_sof) begin
        idx_q <= IDX_W'(1);
        acc_q <= (rx_data == addr_byte(station_addr, '0));
      end else if (idx_q != IDX_FULL) begin
        idx_q <= idx_q + 1'b1;
        acc_q <= acc_q & (rx_data == addr_byte(station_addr, pos));
      end
    end
  end

  assign dest_ok    = acc_q & (idx_q == IDX_FULL);
  assign in_payload = rx_valid & ~rx_sof & (idx_q == IDX_FULL);

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_FULL);
endmodule

// File: rtl/wol_pattern_search.sv
module wol_pattern_search
  import wol_pkg::*;
#(
  parameter int SYNC_LEN        = 6,
  parameter int COPIES          = 16,
  parameter logic [7:0] SYNC_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             frame_start,
  input  logic             byte_en,
  input  logic [7:0]       rx_data,
  input  logic [MAC_W-1:0] station_addr,
  output logic             hit
);
  localparam int FF_W = $clog2(SYNC_LEN + 1);
  localparam int CP_W = (COPIES > 1) ? $clog2(COPIES) : 1;
  localparam logic [FF_W-1:0] FF_FULL   = FF_W'(SYNC_LEN);
  localparam logic [CP_W-1:0] CP_LAST   = CP_W'(COPIES - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(MAC_BYTES - 1);

  logic [FF_W-1:0]  ff_cnt;
  logic             in_copy;
  logic [POS_W-1:0] pos_q;
  logic [CP_W-1:0]  copy_q;
  logic             found_q;

  logic byte_match, is_sync, sync_full, last_byte, last_copy, found_now;

  assign byte_match = (rx_data == addr_byte(station_addr, pos_q));
  assign is_sync    = (rx_data == SYNC_BYTE);
  assign sync_full  = (ff_cnt == FF_FULL);
  assign last_byte  = (pos_q == POS_LAST);
  assign last_copy  = (copy_q == CP_LAST);
  assign found_now  = byte_en & ~found_q & in_copy & byte_match & last_byte & last_copy;
  assign hit        = found_q | found_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_cnt <= '0; in_copy <= 1'b0; pos_q <= '0; copy_q <= '0; found_q <= 1'b0;
    end else if (soft_rst || frame_start) begin
      ff_cnt <= '0; in_copy <= 1'b0; pos_q <= '0; copy_q <= '0; found_q <= 1'b0;
    end else if (byte_en && !found_q) begin
      if (!in_copy) begin
        if (is_sync) begin
          ff_cnt <= sync_full ? ff_cnt : ff_cnt + 1'b1;
        end else if (sync_full && byte_match) begin
          in_copy <= 1'b1;
          pos_q   <= POS_W'(1);
          copy_q  <= '0;
        end else begin
          ff_cnt <= '0;
        end
      end else if (byte_match) begin
        if (last_byte) begin
          pos_q <= '0;
          if (last_copy) begin
            found_q <= 1'b1;
            in_copy <= 1'b0;
            ff_cnt  <= '0;
          end else begin
            copy_q <= copy_q + 1'b1;
          end
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end else begin
        in_copy <= 1'b0;
        pos_q   <= '0;
        copy_q  <= '0;
        ff_cnt  <= is_sync ? FF_W'(1) : '0;
      end
    end
  end

  // R5
  found_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_q) |-> $past(in_copy && last_copy && last_byte));
  // R5
  copy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_copy) |-> $past(sync_full));
  // R6
  ff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ff_cnt <= FF_FULL);
endmodule

// File: rtl/wol_ctrl_reg.sv
module wol_ctrl_reg
  import wol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop_set,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              set_evt,
  input  logic              glb_irq_en,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic mode_q, en_q, acc_q, stat_q, ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0; en_q <= 1'b0; acc_q <= 1'b0; stat_q <= 1'b0; ie_q <= 1'b0;
    end else if (soft_rst) begin
      mode_q <= 1'b0; en_q <= 1'b0; acc_q <= 1'b0; stat_q <= 1'b0; ie_q <= 1'b0;
    end else begin
      if (reg_we) begin
        mode_q <= reg_wdata[B_MODE];
        en_q   <= reg_wdata[B_EN];
        acc_q  <= reg_wdata[B_ACC];
        ie_q   <= reg_wdata[B_IE];
      end
      if (stop_set)
        stat_q <= 1'b0;
      else if (set_evt)
        stat_q <= 1'b1;
      else if (reg_we && reg_wdata[B_STAT])
        stat_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[B_MODE] = mode_q;
    reg_rdata[B_EN]   = en_q;
    reg_rdata[B_ACC]  = acc_q;
    reg_rdata[B_STAT] = stat_q;
    reg_rdata[B_IE]   = ie_q;
  end

  assign irq_o = stat_q & ie_q & glb_irq_en;

  // R9
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(set_evt));
  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_wdata[B_STAT] && !set_evt) |-> !stat_q);
  // R11
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_set) |-> !stat_q);
  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (reg_rdata == '0));
endmodule

// File: rtl/wol_detect_top.sv
module wol_detect_top
  import wol_pkg::*;
#(
  parameter int SYNC_LEN          = 6,
  parameter int COPIES            = 16,
  parameter logic [7:0] SYNC_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop_set,
  input  logic              pwr_good,
  input  logic              glb_irq_en,
  input  logic              alt_accept,
  input  logic [MAC_W-1:0]  station_addr,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_crc_ok,
  input  logic [7:0]        rx_data,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic dest_ok, in_payload, hit;
  logic armed, accept_any, addr_pass, frame_done, set_evt;

  wol_dest_filter u_dest (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .station_addr(station_addr), .dest_ok(dest_ok), .in_payload(in_payload)
  );

  wol_pattern_search #(.SYNC_LEN(SYNC_LEN), .COPIES(COPIES), .SYNC_BYTE(SYNC_BYTE)) u_search (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .frame_start(rx_valid & rx_sof), .byte_en(in_payload),
    .rx_data(rx_data), .station_addr(station_addr), .hit(hit)
  );

  assign armed      = reg_rdata[B_MODE] & (pwr_good | reg_rdata[B_EN]);
  assign accept_any = reg_rdata[B_ACC] | alt_accept;
  assign addr_pass  = dest_ok | accept_any;
  assign frame_done = in_payload & rx_eof & rx_crc_ok;
  assign set_evt    = frame_done & armed & addr_pass & hit;

  wol_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_set(stop_set),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .set_evt(set_evt),
    .glb_irq_en(glb_irq_en), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // R8
  armed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[B_STAT]) |-> $past(reg_rdata[B_MODE]));
endmodule

// File: tb/wol_detect_top_tb_top.sv
module wol_detect_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;
  localparam logic [47:0] STA = 48'h021A3C557E91;

  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, stop_set = 1'b0, pwr_good = 1'b0;
  logic glb_irq_en = 1'b0, alt_accept = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
  logic [7:0] rx_data = '0;
  logic reg_we = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  wol_detect_top dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_set(stop_set),
    .pwr_good(pwr_good), .glb_irq_en(glb_irq_en), .alt_accept(alt_accept),
    .station_addr(STA), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_crc_ok(rx_crc_ok), .rx_data(rx_data), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit m_mode, m_en, m_acc, m_stat, m_ie;
  byte unsigned mq[$];
  byte unsigned fq[$];

  function automatic byte unsigned sta_b(int k);
    return STA[47 - 8*(k % 6) -: 8];
  endfunction

  function automatic bit m_hit();
    bit dst, pat;
    if (mq.size() < 7) return 0;
    dst = 1;
    for (int k = 0; k < 6; k++) if (mq[k] != sta_b(k)) dst = 0;
    if (!(dst || m_acc || alt_accept)) return 0;
    pat = 0;
    for (int p = 6; p + 6 + 96 <= mq.size(); p++) begin
      bit ok = 1;
      for (int k = 0; k < 6; k++) if (mq[p+k] != 8'hFF) ok = 0;
      for (int k = 0; k < 96; k++) if (mq[p+6+k] != sta_b(k)) ok = 0;
      if (ok) pat = 1;
    end
    return pat;
  endfunction

  task automatic tick();
    bit set;
    if (!rst_n || soft_rst) begin
      {m_mode, m_en, m_acc, m_stat, m_ie} = '0;
      mq.delete();
    end else begin
      if (rx_valid) begin
        if (rx_sof) mq.delete();
        mq.push_back(rx_data);
      end
      set = rx_valid && rx_eof && rx_crc_ok && m_mode && (pwr_good || m_en) && m_hit();
      if (stop_set) m_stat = 0;
      else if (set) m_stat = 1;
      else if (reg_we && reg_wdata[3]) m_stat = 0;
      if (reg_we) begin
        m_mode = reg_wdata[0]; m_en = reg_wdata[1];
        m_acc = reg_wdata[2]; m_ie = reg_wdata[4];
      end
    end
    @(posedge clk);
    #1;
    checks++;
    if (reg_rdata !== {m_ie, m_stat, m_acc, m_en, m_mode} ||
        irq_o !== (m_stat & m_ie & glb_irq_en)) begin
      errors++;
      $display("FAIL %s: rdata=%b irq=%b expected rdata=%b irq=%b", cur_req,
               reg_rdata, irq_o, {m_ie, m_stat, m_acc, m_en, m_mode},
               m_stat & m_ie & glb_irq_en);
    end
  endtask

  task automatic chk(string req, logic [4:0] exp_r, logic exp_i);
    checks++;
    if (reg_rdata !== exp_r || irq_o !== exp_i) begin
      errors++;
      $display("FAIL %s: rdata=%b irq=%b expected rdata=%b irq=%b",
               req, reg_rdata, irq_o, exp_r, exp_i);
    end
  endtask

  task automatic wr(logic [4:0] d);
    reg_we = 1; reg_wdata = d; tick(); reg_we = 0; reg_wdata = '0;
  endtask

  function automatic void build(logic [47:0] dst, int junk, int nff, int ncp, int trail);
    fq.delete();
    for (int k = 0; k < 6; k++) fq.push_back(dst[47 - 8*k -: 8]);
    for (int k = 0; k < 6; k++) fq.push_back(8'h10 + k);
    fq.push_back(8'h08); fq.push_back(8'h42);
    for (int k = 0; k < junk; k++) fq.push_back(8'h30 + k);
    for (int k = 0; k < nff; k++) fq.push_back(8'hFF);
    for (int k = 0; k < 6*ncp; k++) fq.push_back(sta_b(k));
    for (int k = 0; k < trail; k++) fq.push_back(8'h55);
  endfunction

  task automatic send(bit crc, int gap, bit w1c_eof, logic [4:0] cfg);
    for (int i = 0; i < fq.size(); i++) begin
      rx_valid = 1; rx_data = fq[i];
      rx_sof = (i == 0); rx_eof = (i == fq.size() - 1);
      rx_crc_ok = crc && rx_eof;
      if (w1c_eof && rx_eof) begin reg_we = 1; reg_wdata = cfg | 5'b01000; end
      tick();
      reg_we = 0; reg_wdata = '0;
      rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0;
      for (int g = 0; g < gap; g++) tick();
    end
    tick();
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", MAX_CYCLES);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] cfg;
    repeat (3) tick();
    #1 rst_n = 1;
    tick();
    chk("R1", 5'b00000, 1'b0);

    cur_req = "R2";
    wr(5'b11111); chk("R2", 5'b10111, 1'b0);
    wr(5'b00000); chk("R2", 5'b00000, 1'b0);

    cur_req = "R5"; cfg = 5'b00011; wr(cfg);
    build(STA, 3, 6, 16, 2); send(1, 0, 0, cfg);
    chk("R5", 5'b01011, 1'b0);

    cur_req = "R10"; cfg = 5'b10011; wr(cfg);
    chk("R10", 5'b11011, 1'b0);
    glb_irq_en = 1; tick(); chk("R10", 5'b11011, 1'b1);
    cur_req = "R9";
    wr(cfg); chk("R9", 5'b11011, 1'b1);
    wr(cfg | 5'b01000); chk("R9", 5'b10011, 1'b0);
    build(STA, 0, 6, 16, 0); send(1, 0, 1, cfg);
    chk("R9", 5'b11011, 1'b1);
    glb_irq_en = 0; tick(); chk("R10", 5'b11011, 1'b0);
    wr(cfg | 5'b01000);

    cur_req = "R7";
    build(STA, 2, 6, 16, 1); send(0, 0, 0, cfg); chk("R7", 5'b10011, 1'b0);
    build(STA, 2, 6, 16, 1); send(1, 2, 0, cfg); chk("R7", 5'b11011, 1'b0);
    wr(cfg | 5'b01000);
    build(STA, 0, 6, 10, 0); send(1, 0, 0, cfg);
    build(STA, 0, 0, 6, 0); send(1, 0, 0, cfg); chk("R7", 5'b10011, 1'b0);

    cur_req = "R3";
    build(48'h021A3C557E90, 0, 6, 16, 0); send(1, 0, 0, cfg); chk("R3", 5'b10011, 1'b0);
    cur_req = "R4"; alt_accept = 1;
    build(48'hFFFFFFFFFFFF, 0, 6, 16, 0); send(1, 0, 0, cfg); chk("R4", 5'b11011, 1'b0);
    alt_accept = 0; cfg = 5'b10111; wr(cfg | 5'b01000);
    build(48'h01005E000001, 1, 6, 16, 0); send(1, 0, 0, cfg); chk("R4", 5'b11111, 1'b0);
    cfg = 5'b10011; wr(cfg | 5'b01000);

    cur_req = "R5";
    build(STA, 0, 6, 15, 3); send(1, 0, 0, cfg); chk("R5", 5'b10011, 1'b0);
    build(STA, 0, 9, 16, 0); send(1, 0, 0, cfg); chk("R5", 5'b11011, 1'b0);
    wr(cfg | 5'b01000);

    cur_req = "R6";
    build(STA, 0, 6, 3, 0);
    for (int k = 0; k < 6; k++) fq.push_back(8'hFF);
    for (int k = 0; k < 96; k++) fq.push_back(sta_b(k));
    send(1, 0, 0, cfg); chk("R6", 5'b11011, 1'b0);
    wr(cfg | 5'b01000);
    build(STA, 0, 6, 2, 0); fq.push_back(8'h00);
    for (int k = 0; k < 96; k++) fq.push_back(sta_b(k));
    send(1, 0, 0, cfg); chk("R6", 5'b10011, 1'b0);

    cur_req = "R8"; cfg = 5'b00001; wr(cfg);
    build(STA, 0, 6, 16, 0); send(1, 0, 0, cfg); chk("R8", 5'b00001, 1'b0);
    pwr_good = 1;
    build(STA, 0, 6, 16, 0); send(1, 0, 0, cfg); chk("R8", 5'b01001, 1'b0);
    cfg = 5'b00010; wr(cfg | 5'b01000);
    build(STA, 0, 6, 16, 0); send(1, 0, 0, cfg); chk("R8", 5'b00010, 1'b0);
    pwr_good = 0;

    cur_req = "R11"; cfg = 5'b10111; wr(cfg);
    build(STA, 0, 6, 16, 0); send(1, 0, 0, cfg); chk("R11", 5'b11111, 1'b0);
    stop_set = 1; tick(); stop_set = 0; chk("R11", 5'b10111, 1'b0);
    soft_rst = 1; tick(); soft_rst = 0; chk("R11", 5'b00000, 1'b0);
    repeat (3) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule